// File: doc/BRIEF.md
# Serial-Loaded Reference Code Register for a Two-Segment Ladder DAC

This block receives a 12-bit reference code over a write-only SPI link (mode 0, most significant bit first) and presents it to two 6-bit resistor-ladder segments. The SPI pins are brought into the system clock domain through synchronizer stages. While chip select is low, bits move into a staging shift register. The register that drives the ladders does not change during this time.

When chip select returns high after exactly twelve rising serial-clock edges, the staged word is copied into the holding register in one step. Any other frame length is dropped and the previous code stays. The holding register drives the ladder switch inverters with inverted levels. The upper half of the code drives the coarse segment and the lower half drives the fine segment.

Top module: `dac_code_port`

## Requirements
- R1: A falling edge on `spi_csn` starts a new frame and clears the bit count, so an earlier aborted frame does not affect the next one.
- R2: The holding register updates only when exactly 12 rising `spi_sclk` edges occur between the falling and rising edges of `spi_csn`; frames of 11 or 13 bits leave the outputs unchanged.
- R3: While a frame is being shifted in, `ladder_hi_n` and `ladder_lo_n` keep their previous values.
- R4: On the rising edge of `spi_csn` that ends a valid frame, the staged 12-bit word becomes the held code, visible at the outputs a few system clocks later.
- R5: Each output bit is the inverse of the corresponding held code bit (held 1 gives output 0).
- R6: `ladder_hi_n` carries the inverse of code bits 11..6 and `ladder_lo_n` the inverse of code bits 5..0, with bit order kept.
- R7: `spi_mosi` is sampled on the rising edge of `spi_sclk`, and the first bit of a frame is code bit 11.
- R8: A synchronous reset (`rst` high) clears the held code to zero, so both outputs read all ones.
- R9: `spi_sclk` and `spi_mosi` activity while `spi_csn` is high is ignored: the outputs do not change and the next frame's bit count is not affected.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data, MSB first |
| ladder_hi_n | output | 6 | Inverted switch drive for the coarse segment (code bits 11..6) |
| ladder_lo_n | output | 6 | Inverted switch drive for the fine segment (code bits 5..0) |

## Verification
The bench sends a strided sweep of codes, together with all-zero, all-one and alternating patterns. A design that swapped the segments, dropped the inversion or shifted LSB first would show a mismatch on almost every code. Frames one bit short and one bit long are sent; a design that counted loosely would latch a shifted word instead of keeping the old one. The outputs are also sampled in the middle of a frame to catch a design that wrote through without double buffering. Serial clocks sent while chip select is high, and a short frame directly followed by a good one, expose a bit count that is not cleared at the start of a frame.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  localparam int unsigned SEG_W_DEFAULT = 6;
  localparam int unsigned SYNC_DEFAULT  = 2;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return $clog2(limit + 2);
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{IDLE}};
      last  <= IDLE;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      last  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;
  assign fall  = ~chain[STAGES-1] & last;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_level,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sdi,
  output logic [CODE_W-1:0] staged,
  output logic              commit
);
  localparam int unsigned CW = dacreg_pkg::cnt_width(CODE_W);
  localparam logic [CW-1:0] FULL = CW'(CODE_W);
  localparam logic [CW-1:0] OVER = CW'(CODE_W + 1);

  logic [CW-1:0] bits_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged    <= '0;
      bits_seen <= '0;
      commit    <= 1'b0;
    end else begin
      commit <= cs_rise && (bits_seen == FULL);
      if (cs_fall) begin
        bits_seen <= '0;
      end else if (!cs_level && sck_rise) begin
        staged <= {staged[CODE_W-2:0], sdi};
        if (bits_seen != OVER) bits_seen <= bits_seen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hold_latch.sv
module hold_latch #(
  parameter int unsigned SEG_W = 6,
  parameter int unsigned SEG_N = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [SEG_W*SEG_N-1:0] word,
  output logic [SEG_W*SEG_N-1:0] drive_n
);
  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst)
        drive_n[s*SEG_W +: SEG_W] <= '1;
      else if (load)
        drive_n[s*SEG_W +: SEG_W] <= ~word[s*SEG_W +: SEG_W];
    end
  end
endmodule

// File: rtl/dac_code_port.sv
module dac_code_port #(
  parameter int unsigned SEG_W  = dacreg_pkg::SEG_W_DEFAULT,
  parameter int unsigned STAGES = dacreg_pkg::SYNC_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sclk,
  input  logic             spi_csn,
  input  logic             spi_mosi,
  output logic [SEG_W-1:0] ladder_hi_n,
  output logic [SEG_W-1:0] ladder_lo_n
);
  localparam int unsigned SEG_N  = 2;
  localparam int unsigned CODE_W = SEG_W * SEG_N;

  logic cs_level, cs_rise, cs_fall;
  logic sck_level, sck_rise, sck_fall;
  logic sdi, sdi_rise, sdi_fall;
  logic [CODE_W-1:0] staged;
  logic              commit;
  logic [CODE_W-1:0] drive_n;

  pin_sync #(.STAGES(STAGES), .IDLE(1'b1)) u_cs (
    .clk(clk), .rst(rst), .pin(spi_csn),
    .level(cs_level), .rise(cs_rise), .fall(cs_fall));
  pin_sync #(.STAGES(STAGES), .IDLE(1'b0)) u_sck (
    .clk(clk), .rst(rst), .pin(spi_sclk),
    .level(sck_level), .rise(sck_rise), .fall(sck_fall));
  pin_sync #(.STAGES(STAGES), .IDLE(1'b0)) u_sdi (
    .clk(clk), .rst(rst), .pin(spi_mosi),
    .level(sdi), .rise(sdi_rise), .fall(sdi_fall));

  frame_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst(rst), .cs_level(cs_level), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sck_rise(sck_rise), .sdi(sdi),
    .staged(staged), .commit(commit));

  hold_latch #(.SEG_W(SEG_W), .SEG_N(SEG_N)) u_hold (
    .clk(clk), .rst(rst), .load(commit), .word(staged), .drive_n(drive_n));

  assign ladder_hi_n = drive_n[CODE_W-1:SEG_W];
  assign ladder_lo_n = drive_n[SEG_W-1:0];
endmodule

// File: rtl/dac_code_port_chk.sv
module dac_code_port_chk #(
  parameter int unsigned SEG_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_level,
  input logic             commit,
  input logic [2*SEG_W-1:0] staged,
  input logic [SEG_W-1:0] ladder_hi_n,
  input logic [SEG_W-1:0] ladder_lo_n
);
  // R8: reset leaves every switch drive high
  p_reset_ones_r8: assert property (@(posedge clk)
    rst |=> (ladder_hi_n == '1 && ladder_lo_n == '1));

  // R3: outputs move only after a commit pulse
  p_hold_steady_r3: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(ladder_hi_n) && $stable(ladder_lo_n)));

  // R4 / R5: a commit pulse loads the inverted staged word
  p_commit_load_r4: assert property (@(posedge clk) disable iff (rst)
    commit |=> ({ladder_hi_n, ladder_lo_n} == ~$past(staged)));

  // R9: nothing shifts while chip select is high
  p_idle_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    cs_level |=> $stable(staged));

  // R2: a commit only happens after the frame has ended
  p_commit_idle_r2: assert property (@(posedge clk) disable iff (rst)
    commit |-> cs_level);
endmodule

bind dac_code_port dac_code_port_chk #(.SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst(rst), .cs_level(cs_level), .commit(commit),
  .staged(staged), .ladder_hi_n(ladder_hi_n), .ladder_lo_n(ladder_lo_n));

// File: tb/test_dac_code_port.sv
module test_dac_code_port;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic csn = 1'b1;
  logic mosi = 1'b0;
  logic [5:0] hi_n, lo_n;

  int checks = 0;
  int errors = 0;
  logic [11:0] held = 12'h000;

  always #10 clk = ~clk;

  dac_code_port i_dac_code_port (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .ladder_hi_n(hi_n), .ladder_lo_n(lo_n));

  task automatic check_out(input logic [11:0] code, input string req);
    logic [11:0] got;
    got = {hi_n, lo_n};
    checks++;
    if (hi_n !== ~code[11:6] || lo_n !== ~code[5:0]) begin
      errors++;
      $display("FAIL %s: outputs=%03h expected=%03h", req, got, ~code);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // send nbits of word, MSB first; optionally sample outputs mid-frame
  task automatic frame(input logic [15:0] word, input int nbits, input bit mid);
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = word[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
      if (mid && i == nbits / 2) check_out(held, "R3 mid-frame hold");
    end
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(8);
  endtask

  task automatic good(input logic [11:0] code, input string req);
    frame({4'h0, code}, 12, 1'b0);
    held = code;
    check_out(held, req);
  endtask

  initial begin
    wait_clk(4);
    check_out(12'h000, "R8 reset all ones");
    rst = 1'b0;
    wait_clk(4);
    check_out(12'h000, "R8 after reset");

    good(12'hFFF, "R5 all ones code");
    good(12'hFC0, "R6 upper segment only");
    good(12'h03F, "R6 lower segment only");
    good(12'h800, "R7 first bit is MSB");
    good(12'h001, "R7 last bit is LSB");
    good(12'hA5A, "R4 alternating");

    frame(16'h0123, 12, 1'b1);
    held = 12'h123;
    check_out(held, "R4 after mid-frame check");

    frame(16'h0555, 11, 1'b0);
    check_out(held, "R2 short frame dropped");
    frame(16'h1ABC, 13, 1'b0);
    check_out(held, "R2 long frame dropped");

    for (int k = 0; k < 20; k++) begin
      mosi = k[0];
      sclk = 1'b1; wait_clk(HALF);
      sclk = 1'b0; wait_clk(HALF);
    end
    wait_clk(8);
    check_out(held, "R9 idle clocks ignored");
    good(12'h6C3, "R9 frame after idle clocks");

    frame(16'h0777, 5, 1'b0);
    good(12'h39E, "R1 count cleared at frame start");

    for (int k = 0; k < 128; k++) begin
      logic [11:0] c;
      c = 12'((k * 1237 + 29) % 4096);
      good(c, "R4 sweep");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule